// File: doc/BRIEF.md
# Block Lock Write Protection Unit

This unit owns the status register of a small byte-addressed nonvolatile memory and decides, request by request, whether a status write or an array write may go ahead. It keeps four pieces of state: a write-enable latch, a two-bit array lock code, a lock-enable bit and a busy flag. The serial front end turns host commands into one-cycle requests. This unit answers each request in the same cycle with a permit or a deny. Granted writes start a self-timed cycle, and the unit marks it busy until the memory controller reports completion.

Two protection layers combine. The lock code fences off an upper part of the array: the top quarter, the top half or all of it. The lock-enable bit, together with an active-low protect pin, forms a hardware lock over the status register itself. When the lock-enable bit is set and the pin is held low, no status write can clear the bit again. Persistent bits are plain registers with parameterised reset values.

Top module: `blk_wprot_unit`

## Requirements
- R1: After a synchronous active-low reset with default parameters, `status_byte` reads 0x00.
- R2: A `wren_req` pulse sets the write-enable latch and a `wrdi_req` pulse clears it. If both arrive in one cycle, the clear wins. The latch is visible as bit 1 of `status_byte` from the next cycle.
- R3: When idle, `status_byte` is laid out as bit 7 = lock-enable, bits 6:4 = 0, bits 3:2 = lock code, bit 1 = write-enable latch, bit 0 = 0.
- R4: While the write-enable latch is 0, both `sts_wr_ok` and `arr_wr_ok` stay 0.
- R5: The hardware lock is active exactly when `wp_n` is 0 and the lock-enable bit is 1. While it is active, every status write is denied and leaves the status unchanged, including a write that would clear lock-enable.
- R6: A granted status write loads `sts_wr_ena` into the lock-enable bit and `sts_wr_code` into the lock code. Neither the latch nor the busy flag is taken from the written data.
- R7: Lock code 0 protects no address, 1 protects 0x1800-0x1FFF, 2 protects 0x1000-0x1FFF and 3 protects 0x0000-0x1FFF. An array write is denied inside the protected range and permitted outside it, with or without the hardware lock.
- R8: A granted write makes the unit busy from the next cycle. While busy, `status_byte` reads 0xFF and every write request is denied.
- R9: `cycle_done` while busy clears both the busy flag and the write-enable latch at the next edge. `cycle_done` while idle has no effect, and `wren_req`/`wrdi_req` while busy are ignored.
- R10: When a status write and an array write are requested in the same cycle, only the status write is considered and `arr_wr_ok` is 0.
- R11: `sts_wr_ok` and `arr_wr_ok` are combinational answers to the request in the same cycle. Each is 1 only while its request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_req | input | 1 | Set the write-enable latch |
| wrdi_req | input | 1 | Clear the write-enable latch |
| sts_wr_req | input | 1 | Status write request |
| sts_wr_ena | input | 1 | New lock-enable value carried by a status write |
| sts_wr_code | input | 2 | New lock code carried by a status write |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Target address of the array write |
| wp_n | input | 1 | Write-protect pin level, active low |
| cycle_done | input | 1 | End of the self-timed write cycle |
| sts_wr_ok | output | 1 | Status write permitted |
| arr_wr_ok | output | 1 | Array write permitted |
| status_byte | output | 8 | Status as seen by a status read |

## Verification
The permits are combinational, so they are due in the same cycle as the request. The bench drives each request just after a falling edge and compares the permits against its model one time unit later, before the rising edge that would consume them. Every state change (latch, lock bits, busy) shows on `status_byte` one rising edge after the cycle that caused it. The bench therefore updates its model only after checking and compares the status at the following falling edge. The checker properties follow the same rule: permit checks use the same edge, and busy and latch checks use `|=>`.

// File: rtl/bwp_pkg.sv
// Package for the block lock write protection unit.
// Holds the lock code type and the status bit positions that readers decode.
package bwp_pkg;

    // Array lock code: how much of the upper address space is fenced off.
    typedef enum logic [1:0] {
        LOCK_NONE    = 2'd0,
        LOCK_QUARTER = 2'd1,
        LOCK_HALF    = 2'd2,
        LOCK_ALL     = 2'd3
    } lock_code_t;

    // Status byte bit positions (readers depend on these).
    localparam int unsigned ST_LOCK_EN = 7;
    localparam int unsigned ST_CODE_HI = 3;
    localparam int unsigned ST_CODE_LO = 2;
    localparam int unsigned ST_WEL     = 1;
    localparam int unsigned ST_BUSY    = 0;
    localparam int unsigned ST_W       = 8;

endpackage

// File: rtl/bwp_region_decode.sv
// Address range decoder.
// Reports whether an array address falls inside the range fenced off by the lock code.
// Assumes ADDR_W >= 2. Uses a full-width threshold compare, so every address bit participates.
module bwp_region_decode
    import bwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  lock_code_t        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1,  {(ADDR_W-1){1'b0}}};

    // Compare the address against the lower bound selected by the code.
    always_comb begin
        case (code)
            LOCK_NONE:    hit = 1'b0;
            LOCK_QUARTER: hit = (addr >= QTR_BASE);
            LOCK_HALF:    hit = (addr >= HALF_BASE);
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/bwp_grant_logic.sv
// Permit logic.
// Decides in the same cycle whether the pending status or array write may start.
// Assumes the requests are single-cycle pulses from the command decoder.
module bwp_grant_logic (
    input  logic wel,
    input  logic busy,
    input  logic lock_en,
    input  logic wp_n,
    input  logic region_hit,
    input  logic sts_req,
    input  logic arr_req,
    output logic sts_ok,
    output logic arr_ok
);
    logic hw_lock;
    logic open_gate;

    // Hardware lock: pin low and enable bit set.
    always_comb hw_lock = lock_en & ~wp_n;

    // Any write needs the latch set and no cycle running.
    always_comb open_gate = wel & ~busy;

    // Status write: gate open and no hardware lock.
    always_comb sts_ok = sts_req & open_gate & ~hw_lock;

    // Array write: gate open, address outside the fence, and no status write competing.
    always_comb arr_ok = arr_req & ~sts_req & open_gate & ~region_hit;
endmodule

// File: rtl/bwp_status_regs.sv
// Status state holder.
// Keeps lock-enable, lock code, write-enable latch and busy flag.
// Assumes sts_ok and arr_ok come from the permit logic and are never 1 while busy.
module bwp_status_regs
    import bwp_pkg::*;
#(
    parameter logic       RST_LOCK_EN = 1'b0,
    parameter lock_code_t RST_CODE    = LOCK_NONE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wren,
    input  logic       wrdi,
    input  logic       sts_ok,
    input  logic       arr_ok,
    input  logic       new_lock_en,
    input  lock_code_t new_code,
    input  logic       cycle_done,
    output logic       lock_en,
    output lock_code_t code,
    output logic       wel,
    output logic       busy
);
    // Persistent protection bits: loaded only by a permitted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_en <= RST_LOCK_EN;
            code    <= RST_CODE;
        end else if (sts_ok) begin
            lock_en <= new_lock_en;
            code    <= new_code;
        end
    end

    // Busy flag and latch: a grant starts a cycle; completion ends it and drops the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            wel  <= 1'b0;
        end else if (busy) begin
            if (cycle_done) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end
        end else begin
            busy <= sts_ok | arr_ok;
            if (wrdi)      wel <= 1'b0;
            else if (wren) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/blk_wprot_unit.sv
// Block lock write protection unit, top level.
// Combines the range decoder, the permit logic and the status state, and assembles the status byte.
// Assumes a single clock domain; the serial front end and the storage cells live elsewhere.
module blk_wprot_unit
    import bwp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter logic        RST_LOCK_EN = 1'b0,
    parameter logic [1:0]  RST_CODE    = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_req,
    input  logic              wrdi_req,
    input  logic              sts_wr_req,
    input  logic              sts_wr_ena,
    input  logic [1:0]        sts_wr_code,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    input  logic              wp_n,
    input  logic              cycle_done,
    output logic              sts_wr_ok,
    output logic              arr_wr_ok,
    output logic [ST_W-1:0]   status_byte
);
    lock_code_t code;
    logic       lock_en;
    logic       wel;
    logic       busy;
    logic       region_hit;

    bwp_region_decode #(
        .ADDR_W (ADDR_W)
    ) i_region (
        .code (code),
        .addr (arr_wr_addr),
        .hit  (region_hit)
    );

    bwp_grant_logic i_grant (
        .wel        (wel),
        .busy       (busy),
        .lock_en    (lock_en),
        .wp_n       (wp_n),
        .region_hit (region_hit),
        .sts_req    (sts_wr_req),
        .arr_req    (arr_wr_req),
        .sts_ok     (sts_wr_ok),
        .arr_ok     (arr_wr_ok)
    );

    bwp_status_regs #(
        .RST_LOCK_EN (RST_LOCK_EN),
        .RST_CODE    (lock_code_t'(RST_CODE))
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wren        (wren_req),
        .wrdi        (wrdi_req),
        .sts_ok      (sts_wr_ok),
        .arr_ok      (arr_wr_ok),
        .new_lock_en (sts_wr_ena),
        .new_code    (lock_code_t'(sts_wr_code)),
        .cycle_done  (cycle_done),
        .lock_en     (lock_en),
        .code        (code),
        .wel         (wel),
        .busy        (busy)
    );

    // Status byte: all ones during a cycle, otherwise the packed fields with spare bits at 0.
    always_comb begin
        if (busy) begin
            status_byte = {ST_W{1'b1}};
        end else begin
            status_byte             = '0;
            status_byte[ST_LOCK_EN] = lock_en;
            status_byte[ST_CODE_HI:ST_CODE_LO] = code;
            status_byte[ST_WEL]     = wel;
        end
    end
endmodule

// File: rtl/blk_wprot_unit_chk.sv
// Property checker for the block lock write protection unit.
// Observes only top-level ports; attached to every instance by the bind below.
module blk_wprot_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cycle_done,
    input logic       sts_wr_req,
    input logic       arr_wr_req,
    input logic       sts_wr_ok,
    input logic       arr_wr_ok,
    input logic [7:0] status_byte
);
    AST_WEL_GATES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_ok || arr_wr_ok) |-> status_byte[1]); // R4

    AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] |-> (!sts_wr_ok && !arr_wr_ok)); // R8

    AST_BUSY_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] |-> (status_byte == 8'hFF)); // R8

    AST_HW_LOCK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_byte[7] && !status_byte[0]) |-> !sts_wr_ok); // R5

    AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[0] && status_byte[3:2] == 2'b11) |-> !arr_wr_ok); // R7

    AST_GRANT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_ok || arr_wr_ok) |=> status_byte[0]); // R8

    AST_DONE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[0] && cycle_done) |=> (status_byte[1:0] == 2'b00)); // R9

    AST_IDLE_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[0] |-> (status_byte[6:4] == 3'b000)); // R3

    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_req && arr_wr_req) |-> !arr_wr_ok); // R10

    AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_wr_ok -> sts_wr_req) && (arr_wr_ok -> arr_wr_req))); // R11
endmodule

bind blk_wprot_unit blk_wprot_unit_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_n        (wp_n),
    .cycle_done  (cycle_done),
    .sts_wr_req  (sts_wr_req),
    .arr_wr_req  (arr_wr_req),
    .sts_wr_ok   (sts_wr_ok),
    .arr_wr_ok   (arr_wr_ok),
    .status_byte (status_byte)
);

// File: tb/test_blk_wprot_unit.sv
// Bench for blk_wprot_unit: directed corner cases, then seeded random traffic,
// all compared against a reference model kept in bench variables.
module test_blk_wprot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_req = 1'b0, wrdi_req = 1'b0;
    logic        sts_wr_req = 1'b0, sts_wr_ena = 1'b0;
    logic [1:0]  sts_wr_code = 2'b00;
    logic        arr_wr_req = 1'b0;
    logic [12:0] arr_wr_addr = '0;
    logic        wp_n = 1'b1, cycle_done = 1'b0;
    logic        sts_wr_ok, arr_wr_ok;
    logic [7:0]  status_byte;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic       m_en = 1'b0, m_wel = 1'b0, m_busy = 1'b0;
    logic [1:0] m_code = 2'b00;

    always #5 clk = ~clk;

    blk_wprot_unit i_blk_wprot_unit (
        .clk(clk), .rst_n(rst_n), .wren_req(wren_req), .wrdi_req(wrdi_req),
        .sts_wr_req(sts_wr_req), .sts_wr_ena(sts_wr_ena), .sts_wr_code(sts_wr_code),
        .arr_wr_req(arr_wr_req), .arr_wr_addr(arr_wr_addr), .wp_n(wp_n),
        .cycle_done(cycle_done), .sts_wr_ok(sts_wr_ok), .arr_wr_ok(arr_wr_ok),
        .status_byte(status_byte)
    );

    function automatic logic fenced(input logic [1:0] c, input logic [12:0] a);
        case (c)
            2'd0: return 1'b0;
            2'd1: return a >= 13'h1800;
            2'd2: return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        if (m_busy) return 8'hFF;
        return {m_en, 3'b000, m_code, m_wel, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check permits and status, advance the model.
    task automatic cyc(input string tag, input logic wr, input logic wd,
                       input logic sr, input logic se, input logic [1:0] sc,
                       input logic ar, input logic [12:0] aa,
                       input logic wp, input logic dn);
        logic e_s, e_a;
        wren_req = wr; wrdi_req = wd; sts_wr_req = sr; sts_wr_ena = se;
        sts_wr_code = sc; arr_wr_req = ar; arr_wr_addr = aa; wp_n = wp; cycle_done = dn;
        #1;
        e_s = sr & m_wel & ~m_busy & ~(m_en & ~wp);
        e_a = ar & ~sr & m_wel & ~m_busy & ~fenced(m_code, aa);
        check({tag, " status"}, status_byte, exp_status());
        check({tag, " sts_ok"}, sts_wr_ok, e_s);
        check({tag, " arr_ok"}, arr_wr_ok, e_a);
        if (m_busy) begin
            if (dn) begin m_busy = 1'b0; m_wel = 1'b0; end
        end else begin
            if (e_s) begin m_en = se; m_code = sc; end
            m_busy = e_s | e_a;
            if (wd) m_wel = 1'b0;
            else if (wr) m_wel = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 check("R1 reset status", status_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1 idle after reset");
        // R4: latch clear, everything denied
        cyc("R4 sts no latch", 0, 0, 1, 1, 2'b01, 0, 13'h0, 1, 0);
        cyc("R4 arr no latch", 0, 0, 0, 0, 2'b00, 1, 13'h0010, 1, 0);
        // R2: set, simultaneous set+clear, set again
        cyc("R2 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        idle("R2 latch visible");
        cyc("R2 clear wins", 1, 1, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        idle("R2 latch cleared");
        cyc("R2 set again", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        // R6/R11: status write granted in the same cycle
        cyc("R6 R11 sts write", 0, 0, 1, 1, 2'b10, 0, 13'h0, 1, 0);
        cyc("R8 busy denies", 1, 0, 1, 0, 2'b00, 1, 13'h0, 1, 0);
        cyc("R9 done", 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 1);
        idle("R3 layout 0x88");
        check("R3 layout", status_byte, 8'h88);
        cyc("R9 done while idle", 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 1);
        // R7: half fence boundaries
        cyc("R7 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R7 half 0x1000 denied", 0, 0, 0, 0, 2'b00, 1, 13'h1000, 1, 0);
        cyc("R7 half 0x0FFF ok", 0, 0, 0, 0, 2'b00, 1, 13'h0FFF, 1, 0);
        cyc("R9 wren during busy", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R9 done", 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 1);
        idle("R9 latch dropped");
        // Move to quarter fence, check its edge
        cyc("R7 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R7 code quarter", 0, 0, 1, 1, 2'b01, 0, 13'h0, 1, 0);
        cyc("R7 done", 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 1);
        cyc("R7 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R7 quarter 0x1800 denied", 0, 0, 0, 0, 2'b00, 1, 13'h1800, 1, 0);
        cyc("R7 quarter 0x1FFF denied", 0, 0, 0, 0, 2'b00, 1, 13'h1FFF, 1, 0);
        // R5: pin low with enable set: status locked, clearing enable refused
        cyc("R5 clear enable refused", 0, 0, 1, 0, 2'b00, 0, 13'h0, 0, 0);
        idle("R5 status unchanged");
        cyc("R10 both requests", 0, 0, 1, 0, 2'b00, 1, 13'h0100, 0, 0);
        cyc("R5 R7 arr 0x17FF ok under lock", 0, 0, 0, 0, 2'b00, 1, 13'h17FF, 0, 0);
        cyc("R7 done", 0, 0, 0, 0, 2'b00, 0, 13'h0, 0, 1);
        // R10 with pin high: status wins and array is refused
        cyc("R10 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R10 status wins", 0, 0, 1, 1, 2'b11, 1, 13'h0000, 1, 0);
        cyc("R10 done", 0, 0, 0, 0, 2'b00, 0, 13'h0, 1, 1);
        cyc("R7 set latch", 1, 0, 0, 0, 2'b00, 0, 13'h0, 1, 0);
        cyc("R7 full fence 0x0000 denied", 0, 0, 0, 0, 2'b00, 1, 13'h0000, 1, 0);
        idle("R7 idle");
        // Seeded random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            cyc("RND", ($urandom % 4) == 0, ($urandom % 10) == 0,
                ($urandom % 6) == 0, 1'($urandom), 2'($urandom),
                ($urandom % 3) == 0, 13'($urandom),
                ($urandom % 3) != 0, m_busy ? (r < 5) : (r == 0));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule